// File: doc/BRIEF.md
# Banked Indirect-Addressing Data Memory

This block is the byte-wide data store of a small microcontroller core. The core presents one address per cycle. The memory decodes it in one of two ways. Addresses 40H and above are general-purpose RAM in the bank chosen by a bank register. Addresses below 40H form a special region that is the same in every bank.

Two locations in the special region hold no data of their own. An access to 00H is redirected to the address held in the first pointer register, and that access always lands in bank 0. An access to 02H is redirected to the address held in the second pointer register, and that access lands in the bank the bank register selects. The two pointer registers and the bank register sit in the special region and are read and written like ordinary bytes. An indirect access whose pointer names one of the two redirecting locations reads zero and changes nothing.

Besides full-byte writes, the core can set or clear a single bit of any resolved target. The block does this as a read-modify-write within one cycle. Reads are combinational. Writes and bit operations take effect on the rising clock edge.

Top module: `bim_top`

## Requirements
- R1: A byte written at a direct address 40H..FFH is stored in the bank named by the bank register (banks 0, 2 and 3). A later direct read of the same address in the same bank returns it combinationally, and each bank keeps its own copy.
- R2: The first pointer register is at 01H and the second pointer register is at 03H. Both are 8-bit and read back exactly what was written. The bank register is at 04H and keeps write-data bits [1:0]; it reads back as those two bits with bits [7:2] zero.
- R3: An access at address 00H uses the first pointer register as its target address in bank 0, whatever value the bank register holds.
- R4: An access at address 02H uses the second pointer register as its target address, in the bank named by the bank register.
- R5: When the pointer in use holds 00H or 02H, an indirect read returns 00H. An indirect write or bit operation then leaves the pointers, the bank register and the RAM unchanged.
- R6: Addresses 00H..3FH decode identically in every bank. Locations in that range other than 01H, 03H and 04H read 00H, and writes to them are discarded.
- R7: General-purpose addresses in bank 1 read 00H, and writes to them are discarded.
- R8: When write enable and bit-operation select are both high, bit `bit_idx` of the resolved target (direct or indirect) is set if `bit_val`=1 or cleared if `bit_val`=0, and the other seven bits are kept. When bit-operation select is low, write enable stores `wdata` whole.
- R9: A synchronous reset clears both pointer registers and the bank register. It leaves the RAM contents untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Access address |
| wdata | input | 8 | Byte write data |
| we | input | 1 | Write enable (byte or bit operation) |
| bit_op | input | 1 | 1 selects a single-bit operation |
| bit_val | input | 1 | Value for the bit operation: 1 sets, 0 clears |
| bit_idx | input | 3 | Bit index for the bit operation |
| rdata | output | 8 | Combinational read data of the resolved target |

## Verification
Pointer redirection and pointer update can fall in the same cycle. This happens when an indirect write goes to the very pointer that performs the redirection. The bench sets the second pointer to 03H and then writes 48H through 02H. It judges the result by reading 03H, which must now hold 48H, and then reading 02H, which must return the RAM byte that was stored earlier at 48H. A bit operation through an indirect location is also checked: it reads and rewrites the redirected target in one cycle.

// File: rtl/bim_pkg.sv
package bim_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] IND0_ADDR = 8'h00;
    localparam logic [ADDR_W-1:0] PTR0_ADDR = 8'h01;
    localparam logic [ADDR_W-1:0] IND1_ADDR = 8'h02;
    localparam logic [ADDR_W-1:0] PTR1_ADDR = 8'h03;
    localparam logic [ADDR_W-1:0] BANK_ADDR = 8'h04;
    localparam logic [ADDR_W-1:0] GPR_BASE  = 8'h40;

    typedef enum logic [2:0] {
        TK_NONE,
        TK_PTR0,
        TK_PTR1,
        TK_BANK,
        TK_GPR
    } tgt_kind_e;
endpackage

// File: rtl/bim_resolve.sv
module bim_resolve
    import bim_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] ptr0,
    input  logic [DATA_W-1:0] ptr1,
    input  logic [BANK_W-1:0] bank,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [BANK_W-1:0] tgt_bank,
    output tgt_kind_e         tgt_kind
);
    always_comb begin
        if (addr == IND0_ADDR) begin
            tgt_addr = ptr0;
            tgt_bank = '0;
        end else if (addr == IND1_ADDR) begin
            tgt_addr = ptr1;
            tgt_bank = bank;
        end else begin
            tgt_addr = addr;
            tgt_bank = bank;
        end
    end

    always_comb begin
        if (tgt_addr >= GPR_BASE) begin
            tgt_kind = TK_GPR;
        end else begin
            unique case (tgt_addr)
                PTR0_ADDR: tgt_kind = TK_PTR0;
                PTR1_ADDR: tgt_kind = TK_PTR1;
                BANK_ADDR: tgt_kind = TK_BANK;
                default:   tgt_kind = TK_NONE;
            endcase
        end
    end
endmodule

// File: rtl/bim_ptr_regs.sv
module bim_ptr_regs
    import bim_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ptr0,
    input  logic              wr_ptr1,
    input  logic              wr_bank,
    input  logic [DATA_W-1:0] wd,
    output logic [DATA_W-1:0] ptr0,
    output logic [DATA_W-1:0] ptr1,
    output logic [BANK_W-1:0] bank
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr0 <= '0;
            ptr1 <= '0;
            bank <= '0;
        end else begin
            if (wr_ptr0) ptr0 <= wd;
            if (wr_ptr1) ptr1 <= wd;
            if (wr_bank) bank <= wd[BANK_W-1:0];
        end
    end
endmodule

// File: rtl/bim_gpr_banks.sv
module bim_gpr_banks
    import bim_pkg::*;
#(
    parameter int          BANKS     = 4,
    parameter int          BANK_W    = $clog2(BANKS),
    parameter logic [BANKS-1:0] IMPL_MASK = 4'b1101
) (
    input  logic              clk,
    input  logic              we,
    input  logic [BANK_W-1:0] bank,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wd,
    output logic [DATA_W-1:0] rd
);
    localparam int WORDS = (1 << ADDR_W) - int'(GPR_BASE);

    logic [ADDR_W-1:0] idx;
    logic [DATA_W-1:0] rd_b [BANKS];

    assign idx = addr - GPR_BASE;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        if (IMPL_MASK[b]) begin : g_ram
            logic [DATA_W-1:0] mem [WORDS];
            always_ff @(posedge clk) begin
                if (we && (bank == BANK_W'(b))) mem[idx] <= wd;
            end
            assign rd_b[b] = mem[idx];
        end else begin : g_hole
            assign rd_b[b] = '0;
        end
    end

    assign rd = rd_b[bank];
endmodule

// File: rtl/bim_top.sv
module bim_top
    import bim_pkg::*;
#(
    parameter int               BANKS     = 4,
    parameter logic [BANKS-1:0] IMPL_MASK = 4'b1101
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  addr,
    input  logic [7:0]  wdata,
    input  logic        we,
    input  logic        bit_op,
    input  logic        bit_val,
    input  logic [2:0]  bit_idx,
    output logic [7:0]  rdata
);
    localparam int BANK_W = $clog2(BANKS);

    logic [DATA_W-1:0] ptr0, ptr1;
    logic [BANK_W-1:0] bank;
    logic [ADDR_W-1:0] tgt_addr;
    logic [BANK_W-1:0] tgt_bank;
    tgt_kind_e         tgt_kind;
    logic [DATA_W-1:0] gpr_rd;
    logic [DATA_W-1:0] cur;
    logic [DATA_W-1:0] nxt;
    logic [DATA_W-1:0] bmask;

    bim_resolve #(.BANK_W(BANK_W)) u_resolve (
        .addr     (addr),
        .ptr0     (ptr0),
        .ptr1     (ptr1),
        .bank     (bank),
        .tgt_addr (tgt_addr),
        .tgt_bank (tgt_bank),
        .tgt_kind (tgt_kind)
    );

    always_comb begin
        unique case (tgt_kind)
            TK_PTR0: cur = ptr0;
            TK_PTR1: cur = ptr1;
            TK_BANK: cur = DATA_W'(bank);
            TK_GPR:  cur = gpr_rd;
            default: cur = '0;
        endcase
    end

    assign bmask = DATA_W'(1) << bit_idx;

    always_comb begin
        if (!bit_op)      nxt = wdata;
        else if (bit_val) nxt = cur | bmask;
        else              nxt = cur & ~bmask;
    end

    bim_ptr_regs #(.BANK_W(BANK_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_ptr0 (we && tgt_kind == TK_PTR0),
        .wr_ptr1 (we && tgt_kind == TK_PTR1),
        .wr_bank (we && tgt_kind == TK_BANK),
        .wd      (nxt),
        .ptr0    (ptr0),
        .ptr1    (ptr1),
        .bank    (bank)
    );

    bim_gpr_banks #(
        .BANKS     (BANKS),
        .BANK_W    (BANK_W),
        .IMPL_MASK (IMPL_MASK)
    ) u_gpr (
        .clk  (clk),
        .we   (we && tgt_kind == TK_GPR),
        .bank (tgt_bank),
        .addr (tgt_addr),
        .wd   (nxt),
        .rd   (gpr_rd)
    );

    assign rdata = cur;
endmodule

// File: rtl/bim_checker.sv
module bim_checker (
    input logic       clk,
    input logic       rst,
    input logic [7:0] addr,
    input logic [7:0] wdata,
    input logic       we,
    input logic       bit_op,
    input logic [7:0] rdata,
    input logic [7:0] ptr0,
    input logic [7:0] ptr1,
    input logic [1:0] bank
);
    // R9: reset clears both pointers and the bank register
    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (ptr0 == 8'h00 && ptr1 == 8'h00 && bank == 2'd0));

    // R2: byte write at 01H lands in the first pointer
    a_r2_ptr0_write: assert property (@(posedge clk) disable iff (rst)
        (we && !bit_op && addr == 8'h01) |=> (ptr0 == $past(wdata)));

    // R5: self-pointing indirect read returns zero
    a_r5_self_read_zero: assert property (@(posedge clk) disable iff (rst)
        ((addr == 8'h00 && (ptr0 == 8'h00 || ptr0 == 8'h02)) ||
         (addr == 8'h02 && (ptr1 == 8'h00 || ptr1 == 8'h02))) |-> (rdata == 8'h00));

    // R5: self-pointing indirect write leaves the registers alone
    a_r5_self_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (we && ((addr == 8'h00 && (ptr0 == 8'h00 || ptr0 == 8'h02)) ||
                (addr == 8'h02 && (ptr1 == 8'h00 || ptr1 == 8'h02))))
        |=> ($stable(ptr0) && $stable(ptr1) && $stable(bank)));

    // R6: unused low locations read zero
    a_r6_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (addr >= 8'h05 && addr < 8'h40) |-> (rdata == 8'h00));

    // R7: bank 1 general-purpose space reads zero
    a_r7_bank1_zero: assert property (@(posedge clk) disable iff (rst)
        (addr >= 8'h40 && bank == 2'd1) |-> (rdata == 8'h00));

    // R2: bank register reads with upper bits zero
    a_r2_bank_readback: assert property (@(posedge clk) disable iff (rst)
        (addr == 8'h04) |-> (rdata == {6'b0, bank}));
endmodule

bind bim_top bim_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .addr   (addr),
    .wdata  (wdata),
    .we     (we),
    .bit_op (bit_op),
    .rdata  (rdata),
    .ptr0   (ptr0),
    .ptr1   (ptr1),
    .bank   (bank)
);

// File: tb/tb_bim_top.sv
module tb_bim_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 47;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       we = 1'b0;
    logic       bit_op = 1'b0;
    logic       bit_val = 1'b0;
    logic [2:0] bit_idx = '0;
    logic [7:0] rdata;

    int applied = 0;
    int miscompares = 0;

    bim_top dut (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .we(we),
        .bit_op(bit_op), .bit_val(bit_val), .bit_idx(bit_idx), .rdata(rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // fields: req[4] chk we bop bval idx[3] addr[8] wdata[8] exp[8]
    localparam logic [34:0] VEC [NV] = '{
        {4'd9, 1'b1,1'b0,1'b0,1'b0,3'd0, 8'h01, 8'h00, 8'h00}, // R9 ptr0 zero
        {4'd1, 1'b0,1'b1,1'b0,1'b0,3'd0, 8'h40, 8'hA5, 8'h00}, // R1 bank0 wr
        {4'd1, 1'b1,1'b0,1'b0,1'b0,3'd0, 8'h40, 8'h00, 8'hA5}, // R1
        {4'd2, 1'b0,1'b1,1'b0,1'b0,3'd0, 8'h04, 8'h02, 8'h00}, // R2 bank=2
        {4'd1, 1'b0,1'b1,1'b0,1'b0,3'd0, 8'h40, 8'h3C, 8'h00}, // R1 bank2 wr
        {4'd1, 1'b1,1'b0,1'b0,1'b0,3'd0, 8'h40, 8'h00, 8'h3C}, // R1
        {4'd2, 1'b0,1'b1,1'b0,1'b0,3'd0, 8'h04, 8'hFF, 8'h00}, // R2 bank=3
        {4'd2, 1'b1,1'b0,1'b0,1'b0,3'd0, 8'h04, 8'h00, 8'h03}, // R2 upper bits zero
        {4'd1, 1'b0,1'b1,1'b0,1'b0,3'd0, 8'h40, 8'h77, 8'h00}, // R1 bank3 wr
        {4'd1, 1'b1,1'b0,1'b0,1'b0,3'd0, 8'h40, 8'h00, 8'h77}, // R1
        {4'd2, 1'b0,1'b1,1'b0,1'b0,3'd0, 8'h04, 8'h01, 8'h00}, // bank=1
        {4'd7, 1'b0,1'b1,1'b0,1'b0,3'd0, 8'h40, 8'h99, 8'h00}, // R7 discarded
        {4'd7, 1'b1,1'b0,1'b0,1'b0,3'd0, 8'h40, 8'h00, 8'h00}, // R7
        {4'd2, 1'b0,1'b1,1'b0,1'b0,3'd0, 8'h01, 8'h40, 8'h00}, // R2 ptr0=40
        {4'd2, 1'b1,1'b0,1'b0,1'b0,3'd0, 8'h01, 8'h00, 8'h40}, // R2
        {4'd3, 1'b1,1'b0,1'b0,1'b0,3'd0, 8'h00, 8'h00, 8'hA5}, // R3 bank0 though bank=1
        {4'd2, 1'b0,1'b1,1'b0,1'b0,3'd0, 8'h03, 8'h40, 8'h00}, // R2 ptr1=40
        {4'd4, 1'b1,1'b0,1'b0,1'b0,3'd0, 8'h02, 8'h00, 8'h00}, // R4 bank1 -> 0
        {4'd2, 1'b0,1'b1,1'b0,1'b0,3'd0, 8'h04, 8'h02, 8'h00}, // bank=2
        {4'd4, 1'b1,1'b0,1'b0,1'b0,3'd0, 8'h02, 8'h00, 8'h3C}, // R4
        {4'd4, 1'b0,1'b1,1'b0,1'b0,3'd0, 8'h02, 8'h5A, 8'h00}, // R4 indirect wr
        {4'd3, 1'b1,1'b0,1'b0,1'b0,3'd0, 8'h00, 8'h00, 8'hA5}, // R3 bank0 intact
        {4'd4, 1'b1,1'b0,1'b0,1'b0,3'd0, 8'h40, 8'h00, 8'h5A}, // R4 landed in bank2
        {4'd6, 1'b0,1'b1,1'b0,1'b0,3'd0, 8'h10, 8'h12, 8'h00}, // R6 discarded
        {4'd6, 1'b1,1'b0,1'b0,1'b0,3'd0, 8'h10, 8'h00, 8'h00}, // R6
        {4'd6, 1'b1,1'b0,1'b0,1'b0,3'd0, 8'h3F, 8'h00, 8'h00}, // R6
        {4'd8, 1'b0,1'b1,1'b1,1'b1,3'd7, 8'h40, 8'h00, 8'h00}, // R8 set bit7
        {4'd8, 1'b1,1'b0,1'b0,1'b0,3'd0, 8'h40, 8'h00, 8'hDA}, // R8
        {4'd8, 1'b0,1'b1,1'b1,1'b0,3'd1, 8'h02, 8'hFF, 8'h00}, // R8 clear bit1 indirect
        {4'd8, 1'b1,1'b0,1'b0,1'b0,3'd0, 8'h02, 8'h00, 8'hD8}, // R8
        {4'd5, 1'b0,1'b1,1'b0,1'b0,3'd0, 8'h01, 8'h02, 8'h00}, // ptr0=02
        {4'd5, 1'b1,1'b0,1'b0,1'b0,3'd0, 8'h00, 8'h00, 8'h00}, // R5 read zero
        {4'd5, 1'b0,1'b1,1'b0,1'b0,3'd0, 8'h00, 8'hFF, 8'h00}, // R5 write ignored
        {4'd5, 1'b1,1'b0,1'b0,1'b0,3'd0, 8'h03, 8'h00, 8'h40}, // R5 ptr1 kept
        {4'd5, 1'b1,1'b0,1'b0,1'b0,3'd0, 8'h01, 8'h00, 8'h02}, // R5 ptr0 kept
        {4'd5, 1'b0,1'b1,1'b0,1'b0,3'd0, 8'h03, 8'h00, 8'h00}, // ptr1=00
        {4'd5, 1'b0,1'b1,1'b0,1'b0,3'd0, 8'h02, 8'h11, 8'h00}, // R5 write ignored
        {4'd5, 1'b1,1'b0,1'b0,1'b0,3'd0, 8'h02, 8'h00, 8'h00}, // R5 read zero
        {4'd5, 1'b1,1'b0,1'b0,1'b0,3'd0, 8'h01, 8'h00, 8'h02}, // R5 ptr0 kept
        {4'd5, 1'b1,1'b0,1'b0,1'b0,3'd0, 8'h04, 8'h00, 8'h02}, // R5 bank kept
        {4'd8, 1'b0,1'b1,1'b1,1'b1,3'd0, 8'h02, 8'h00, 8'h00}, // R8/R5 bit op ignored
        {4'd5, 1'b1,1'b0,1'b0,1'b0,3'd0, 8'h03, 8'h00, 8'h00}, // R5 ptr1 still 00
        {4'd1, 1'b0,1'b1,1'b0,1'b0,3'd0, 8'h48, 8'h66, 8'h00}, // R1 bank2 48=66
        {4'd4, 1'b0,1'b1,1'b0,1'b0,3'd0, 8'h03, 8'h03, 8'h00}, // ptr1=03 (self reg)
        {4'd4, 1'b0,1'b1,1'b0,1'b0,3'd0, 8'h02, 8'h48, 8'h00}, // R4 write ptr1 via itself
        {4'd4, 1'b1,1'b0,1'b0,1'b0,3'd0, 8'h03, 8'h00, 8'h48}, // R4
        {4'd4, 1'b1,1'b0,1'b0,1'b0,3'd0, 8'h02, 8'h00, 8'h66}  // R4 new pointer used
    };

    task automatic check(input int req, input logic [7:0] exp);
        applied++;
        if (rdata !== exp) begin
            miscompares++;
            $display("FAIL R%0d addr=%02h actual=%02h expected=%02h", req, addr, rdata, exp);
        end
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input int req);
        @(negedge clk);
        addr = a; we = 1'b0; bit_op = 1'b0;
        #1 check(req, exp);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {we, bit_op, bit_val, bit_idx, addr, wdata} = VEC[i][23:0] == 24'h0 ? {VEC[i][29:8]} : {VEC[i][29:8]};
            #1;
            if (VEC[i][30]) check(int'(VEC[i][34:31]), VEC[i][7:0]);
        end
        // R9: reset mid-run clears pointers and bank, RAM survives
        @(negedge clk);
        we = 1'b0; bit_op = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd_chk(8'h01, 8'h00, 9); // R9
        rd_chk(8'h03, 8'h00, 9); // R9
        rd_chk(8'h04, 8'h00, 9); // R9
        rd_chk(8'h40, 8'hA5, 9); // R9 bank0 RAM kept
        rd_chk(8'h00, 8'h00, 5); // R5 ptr0=00 after reset
        @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end
endmodule